// File: doc/BRIEF.md
# PCI Configuration Window Bridge

This block sits on a processor-side local bus and converts accesses into a 1 MB configuration window into PCI type-0 configuration requests. Each access address is folded together with a programmable 16-bit mapping register to form a 32-bit configuration tag. The block takes the target device from a one-hot select field in the upper tag bits. It takes the function and the dword-aligned register offset from the low bits. The decoded request goes to a configuration-space responder as a single-cycle strobe. The responder's read data comes back to the processor once the responder acknowledges.

A second, smaller window (selected by `req_ctrl`) holds the block's control registers. The mapping register can be read and written there. A handful of fixed identification and base-address values can be read. Any offset the block does not implement is reported through an error flag. Configuration data is byte-reversed between the processor side and the little-endian configuration side. Control-window data is passed without any byte reordering.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset `req_ready`, `cfg_valid` and `rsp_err` are 0 and the mapping register reads 0.
- R2: A configuration-window request (`req_ctrl`=0) accepted in idle causes `cfg_valid` to be high for exactly the next cycle, with `cfg_write` equal to `req_write`.
- R3: The tag is the 20-bit window offset ORed with (mapping register AND 0xFFF0) shifted left 16. `cfg_dev` is the index minus 24 of the lowest set tag bit among bits 24..31. Those bits are mapping register bits 8..15.
- R4: If tag bits 24..31 are all zero, `cfg_dev` is 0 and `cfg_nodev` is 1, and the completion of that access has `rsp_err`=1. Otherwise both flags are 0.
- R5: `cfg_func` is tag bits 10:8, `cfg_reg` is tag bits 7:2 followed by two zero bits, and `cfg_bus` is 0.
- R6: `cfg_wdata` is `req_wdata` with its four bytes in reversed order. On completion, `rsp_rdata` is the acknowledged `cfg_rdata` with its bytes reversed.
- R7: While waiting, the cycle after `cfg_ack` is seen high, `req_ready` is high for exactly one cycle. Before that it stays low, whatever the acknowledge delay.
- R8: Control offset 0x05E is the 16-bit mapping register. A write stores `req_wdata[15:0]`, and a read returns it zero-extended.
- R9: Control reads return 4 at 0x008, 0x11000000 at 0x018, 0x1100 at 0x062, 1 at 0x064, 0x1D00 at 0x066 and 0 at 0x006, all with `rsp_err`=0.
- R10: Writes to the read-only offsets of R9 complete without error and leave those values unchanged.
- R11: A control access to any other offset completes with `rsp_err`=1. A read returns 0, and a write leaves the mapping register unchanged.
- R12: A control access completes with `req_ready` high the cycle after acceptance and never raises `cfg_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ctrl | input | 1 | 1 = control window, 0 = configuration window |
| req_addr | input | 20 | Offset within the selected window |
| req_wdata | input | 32 | Processor write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `req_ready` |
| rsp_err | output | 1 | Unimplemented offset or missing device, valid with `req_ready` |
| cfg_valid | output | 1 | One-cycle strobe of a decoded configuration request |
| cfg_write | output | 1 | Direction of the configuration request |
| cfg_bus | output | 8 | Bus number, always 0 |
| cfg_dev | output | 3 | Decoded device number |
| cfg_func | output | 3 | Decoded function number |
| cfg_reg | output | 8 | Dword-aligned register offset |
| cfg_nodev | output | 1 | No device select bit was set |
| cfg_wdata | output | 32 | Little-endian write data |
| cfg_ack | input | 1 | Responder acknowledge |
| cfg_rdata | input | 32 | Little-endian read data from the responder |

## Verification
The assertions check on every cycle that the request strobe and the completion pulse each last one cycle and never overlap. They also check that the strobe only follows a pending request, that register offsets are dword aligned, and that a missing select bit always comes with device 0. Which device a mapping value selects, the function and register extraction, byte reversal in both directions, and the control register contents can only be shown by the bench's scenarios. The same holds for ignored writes and the error flag on completion. The bench compares these against models of the tag arithmetic, with random mapping values, random addresses and random acknowledge delays.

// File: rtl/cfgbr_pkg.sv
`timescale 1ns/1ps
package cfgbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CFG  = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    // Control window offsets and the fixed values behind them
    localparam int OFF_STATUS  = 'h006;
    localparam int OFF_REV     = 'h008;
    localparam int OFF_DMABASE = 'h018;
    localparam int OFF_MAPREG  = 'h05E;
    localparam int OFF_MEMBASE = 'h062;
    localparam int OFF_IOEN    = 'h064;
    localparam int OFF_ALTMAP  = 'h066;

    localparam logic [31:0] VAL_REV     = 32'h0000_0004;
    localparam logic [31:0] VAL_DMABASE = 32'h1100_0000;
    localparam logic [31:0] VAL_MEMBASE = 32'h0000_1100;
    localparam logic [31:0] VAL_IOEN    = 32'h0000_0001;
    localparam logic [31:0] VAL_ALTMAP  = 32'h0000_1D00;

endpackage

// File: rtl/cfg_tag_decode.sv
`timescale 1ns/1ps
module cfg_tag_decode #(
    parameter int WIN_ADDR_W = 20,
    parameter int MAP_W      = 16,
    parameter int MAP_SHIFT  = 16,
    parameter int SEL_LO     = 24,
    parameter int NUM_DEV    = 8,
    parameter int DEV_W      = $clog2(NUM_DEV)
) (
    input  logic [WIN_ADDR_W-1:0] win_addr,
    input  logic [MAP_W-1:0]      map,
    output logic [DEV_W-1:0]      dev,
    output logic [2:0]            func,
    output logic [7:0]            regno,
    output logic                  nodev
);
    localparam int TAG_W = SEL_LO + NUM_DEV;
    localparam logic [MAP_W-1:0] MAP_MASK = {{(MAP_W-4){1'b1}}, 4'b0000};

    logic [TAG_W-1:0] tag;
    logic             unused_tag_bits;

    assign tag = TAG_W'(win_addr) | (TAG_W'(map & MAP_MASK) << MAP_SHIFT);
    assign unused_tag_bits = ^{tag[SEL_LO-1:11], tag[1:0]};

    // Lowest set select bit wins: scan downward so the lowest index is written last
    always_comb begin
        dev   = '0;
        nodev = 1'b1;
        for (int i = NUM_DEV - 1; i >= 0; i--) begin
            if (tag[SEL_LO + i]) begin
                dev   = DEV_W'(i);
                nodev = 1'b0;
            end
        end
    end

    assign func  = tag[10:8];
    assign regno = {tag[7:2], 2'b00};

endmodule

// File: rtl/byte_lane_order.sv
`timescale 1ns/1ps
module byte_lane_order #(
    parameter int DATA_W = 32,
    parameter bit SWAP   = 1'b1
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int BYTES = DATA_W / 8;

    generate
        if (SWAP) begin : g_swap
            for (genvar b = 0; b < BYTES; b++) begin : g_lane
                assign dout[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
            end
        end else begin : g_pass
            assign dout = din;
        end
    endgenerate

endmodule

// File: rtl/ctrl_reg_decode.sv
`timescale 1ns/1ps
module ctrl_reg_decode
    import cfgbr_pkg::*;
#(
    parameter int CTRL_ADDR_W = 12,
    parameter int DATA_W      = 32,
    parameter int MAP_W       = 16
) (
    input  logic [CTRL_ADDR_W-1:0] off,
    input  logic [MAP_W-1:0]       map,
    output logic [DATA_W-1:0]      rdata,
    output logic                   hit,
    output logic                   map_sel
);
    always_comb begin
        rdata   = '0;
        hit     = 1'b1;
        map_sel = 1'b0;
        case (off)
            CTRL_ADDR_W'(OFF_STATUS):  rdata = '0;
            CTRL_ADDR_W'(OFF_REV):     rdata = DATA_W'(VAL_REV);
            CTRL_ADDR_W'(OFF_DMABASE): rdata = DATA_W'(VAL_DMABASE);
            CTRL_ADDR_W'(OFF_MEMBASE): rdata = DATA_W'(VAL_MEMBASE);
            CTRL_ADDR_W'(OFF_IOEN):    rdata = DATA_W'(VAL_IOEN);
            CTRL_ADDR_W'(OFF_ALTMAP):  rdata = DATA_W'(VAL_ALTMAP);
            CTRL_ADDR_W'(OFF_MAPREG): begin
                rdata   = DATA_W'(map);
                map_sel = 1'b1;
            end
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfg_window_bridge.sv
`timescale 1ns/1ps
module cfg_window_bridge
    import cfgbr_pkg::*;
#(
    parameter int WIN_ADDR_W  = 20,
    parameter int CTRL_ADDR_W = 12,
    parameter int DATA_W      = 32,
    parameter int MAP_W       = 16,
    parameter int MAP_SHIFT   = 16,
    parameter int SEL_LO      = 24,
    parameter int NUM_DEV     = 8,
    parameter bit CPU_SWAP    = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic                       req_ctrl,
    input  logic [WIN_ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       req_ready,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic                       rsp_err,
    output logic                       cfg_valid,
    output logic                       cfg_write,
    output logic [7:0]                 cfg_bus,
    output logic [$clog2(NUM_DEV)-1:0] cfg_dev,
    output logic [2:0]                 cfg_func,
    output logic [7:0]                 cfg_reg,
    output logic                       cfg_nodev,
    output logic [DATA_W-1:0]          cfg_wdata,
    input  logic                       cfg_ack,
    input  logic [DATA_W-1:0]          cfg_rdata
);
    localparam int DEV_W = $clog2(NUM_DEV);

    typedef struct packed {
        state_e            st;
        logic [MAP_W-1:0]  map;
        logic              cfg_valid;
        logic              cfg_write;
        logic [DEV_W-1:0]  dev;
        logic [2:0]        func;
        logic [7:0]        regno;
        logic              nodev;
        logic [DATA_W-1:0] wdata;
        logic              ready;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } regs_t;

    regs_t d, q;

    logic [DEV_W-1:0]  dec_dev;
    logic [2:0]        dec_func;
    logic [7:0]        dec_reg;
    logic              dec_nodev;
    logic [DATA_W-1:0] wdata_le;
    logic [DATA_W-1:0] rdata_cpu;
    logic [DATA_W-1:0] ctrl_rdata;
    logic              ctrl_hit;
    logic              ctrl_map_sel;

    cfg_tag_decode #(
        .WIN_ADDR_W(WIN_ADDR_W), .MAP_W(MAP_W), .MAP_SHIFT(MAP_SHIFT),
        .SEL_LO(SEL_LO), .NUM_DEV(NUM_DEV), .DEV_W(DEV_W)
    ) u_tag (
        .win_addr(req_addr), .map(q.map),
        .dev(dec_dev), .func(dec_func), .regno(dec_reg), .nodev(dec_nodev)
    );

    byte_lane_order #(.DATA_W(DATA_W), .SWAP(CPU_SWAP)) u_wswap (
        .din(req_wdata), .dout(wdata_le)
    );

    byte_lane_order #(.DATA_W(DATA_W), .SWAP(CPU_SWAP)) u_rswap (
        .din(cfg_rdata), .dout(rdata_cpu)
    );

    ctrl_reg_decode #(
        .CTRL_ADDR_W(CTRL_ADDR_W), .DATA_W(DATA_W), .MAP_W(MAP_W)
    ) u_ctrl (
        .off(req_addr[CTRL_ADDR_W-1:0]), .map(q.map),
        .rdata(ctrl_rdata), .hit(ctrl_hit), .map_sel(ctrl_map_sel)
    );

    always_comb begin
        d           = q;
        d.cfg_valid = 1'b0;
        d.ready     = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_ctrl) begin
                        d.st    = ST_DONE;
                        d.ready = 1'b1;
                        d.err   = ~ctrl_hit;
                        d.rdata = req_write ? '0 : ctrl_rdata;
                        if (req_write && ctrl_map_sel) begin
                            d.map = req_wdata[MAP_W-1:0];
                        end
                    end else begin
                        d.st        = ST_CFG;
                        d.cfg_valid = 1'b1;
                        d.cfg_write = req_write;
                        d.dev       = dec_dev;
                        d.func      = dec_func;
                        d.regno     = dec_reg;
                        d.nodev     = dec_nodev;
                        d.wdata     = wdata_le;
                        d.err       = dec_nodev;
                    end
                end
            end
            ST_CFG: begin
                if (cfg_ack) begin
                    d.st    = ST_DONE;
                    d.ready = 1'b1;
                    d.rdata = rdata_cpu;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready = q.ready;
    assign rsp_rdata = q.rdata;
    assign rsp_err   = q.err;
    assign cfg_valid = q.cfg_valid;
    assign cfg_write = q.cfg_write;
    assign cfg_bus   = '0;
    assign cfg_dev   = q.dev;
    assign cfg_func  = q.func;
    assign cfg_reg   = q.regno;
    assign cfg_nodev = q.nodev;
    assign cfg_wdata = q.wdata;

endmodule

// File: rtl/cfg_window_bridge_chk.sv
`timescale 1ns/1ps
module cfg_window_bridge_chk #(
    parameter int DEV_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             cfg_valid,
    input logic [DEV_W-1:0] cfg_dev,
    input logic [7:0]       cfg_reg,
    input logic             cfg_nodev
);
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> !cfg_valid);

    assert_strobe_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_valid) |-> $past(req_valid));

    assert_nodev_dev_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_nodev) |-> (cfg_dev == '0));

    assert_reg_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_reg[1:0] == 2'b00));

    assert_ready_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && req_ready));

endmodule

bind cfg_window_bridge cfg_window_bridge_chk #(.DEV_W($clog2(NUM_DEV))) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cfg_valid(cfg_valid), .cfg_dev(cfg_dev), .cfg_reg(cfg_reg), .cfg_nodev(cfg_nodev)
);

// File: tb/cfg_window_bridge_test.sv
`timescale 1ns/1ps
module cfg_window_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_ctrl = 1'b0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        cfg_valid;
    logic        cfg_write;
    logic [7:0]  cfg_bus;
    logic [2:0]  cfg_dev;
    logic [2:0]  cfg_func;
    logic [7:0]  cfg_reg;
    logic        cfg_nodev;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] map_m = '0;

    always #2.5 clk = ~clk;

    cfg_window_bridge uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_ctrl(req_ctrl), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_bus(cfg_bus),
        .cfg_dev(cfg_dev), .cfg_func(cfg_func), .cfg_reg(cfg_reg),
        .cfg_nodev(cfg_nodev), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
        .cfg_rdata(cfg_rdata)
    );

    function automatic logic [31:0] swap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] exp_dev(input logic [15:0] m);
        for (int i = 0; i < 8; i++) if (m[8+i]) return i;
        return 0;
    endfunction

    function automatic logic exp_nodev(input logic [15:0] m);
        return (m[15:8] == 8'h00);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_ctrl(input bit wr, input logic [11:0] off, input logic [31:0] wd,
                           input logic [31:0] exp_rd, input bit exp_err, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_ctrl = 1'b1;
        req_addr = {8'h00, off}; req_wdata = wd;
        @(negedge clk);
        chk(req, "ready", 32'(req_ready), 32'd1);
        chk(req, "err", 32'(rsp_err), 32'(exp_err));
        if (!wr) chk(req, "rdata", rsp_rdata, exp_rd);
        chk("R12", "no cfg strobe", 32'(cfg_valid), 32'd0);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R12", "ready drops", 32'(req_ready), 32'd0);
    endtask

    task automatic write_map(input logic [31:0] wd);
        do_ctrl(1'b1, 12'h05E, wd, 32'h0, 1'b0, "R8");
        map_m = wd[15:0];
    endtask

    task automatic do_cfg(input bit wr, input logic [19:0] addr, input logic [31:0] wd,
                          input int delay, input logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_ctrl = 1'b0;
        req_addr = addr; req_wdata = wd;
        @(negedge clk);
        chk("R2", "strobe", 32'(cfg_valid), 32'd1);
        chk("R2", "write", 32'(cfg_write), 32'(wr));
        chk("R3", "dev", 32'(cfg_dev), exp_dev(map_m));
        chk("R4", "nodev", 32'(cfg_nodev), 32'(exp_nodev(map_m)));
        chk("R5", "func", 32'(cfg_func), 32'(addr[10:8]));
        chk("R5", "reg", 32'(cfg_reg), 32'({addr[7:2], 2'b00}));
        chk("R5", "bus", 32'(cfg_bus), 32'd0);
        chk("R6", "wdata", cfg_wdata, swap32(wd));
        for (int k = 0; k < delay; k++) begin
            @(negedge clk);
            chk("R2", "strobe gone", 32'(cfg_valid), 32'd0);
            chk("R7", "ready waits", 32'(req_ready), 32'd0);
        end
        cfg_ack = 1'b1; cfg_rdata = rd;
        @(negedge clk);
        cfg_ack = 1'b0;
        chk("R7", "ready", 32'(req_ready), 32'd1);
        chk("R6", "rdata", rsp_rdata, swap32(rd));
        chk("R4", "err", 32'(rsp_err), 32'(exp_nodev(map_m)));
        req_valid = 1'b0;
        @(negedge clk);
        chk("R7", "ready drops", 32'(req_ready), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ready", 32'(req_ready), 32'd0);
        chk("R1", "cfg_valid", 32'(cfg_valid), 32'd0);
        chk("R1", "err", 32'(rsp_err), 32'd0);
        do_ctrl(1'b0, 12'h05E, 32'h0, 32'h0, 1'b0, "R1");

        // R9 fixed values
        do_ctrl(1'b0, 12'h008, 32'h0, 32'h0000_0004, 1'b0, "R9");
        do_ctrl(1'b0, 12'h018, 32'h0, 32'h1100_0000, 1'b0, "R9");
        do_ctrl(1'b0, 12'h062, 32'h0, 32'h0000_1100, 1'b0, "R9");
        do_ctrl(1'b0, 12'h064, 32'h0, 32'h0000_0001, 1'b0, "R9");
        do_ctrl(1'b0, 12'h066, 32'h0, 32'h0000_1D00, 1'b0, "R9");
        do_ctrl(1'b0, 12'h006, 32'h0, 32'h0, 1'b0, "R9");

        // R8 mapping register
        write_map(32'hABCD_1234);
        do_ctrl(1'b0, 12'h05E, 32'h0, 32'h0000_1234, 1'b0, "R8");

        // R10 read-only writes ignored
        do_ctrl(1'b1, 12'h008, 32'hDEAD_BEEF, 32'h0, 1'b0, "R10");
        do_ctrl(1'b0, 12'h008, 32'h0, 32'h0000_0004, 1'b0, "R10");
        do_ctrl(1'b1, 12'h066, 32'hFFFF_FFFF, 32'h0, 1'b0, "R10");
        do_ctrl(1'b0, 12'h066, 32'h0, 32'h0000_1D00, 1'b0, "R10");

        // R11 unimplemented offsets
        do_ctrl(1'b0, 12'h100, 32'h0, 32'h0, 1'b1, "R11");
        do_ctrl(1'b1, 12'h05C, 32'h0000_5555, 32'h0, 1'b1, "R11");
        do_ctrl(1'b0, 12'h05E, 32'h0, 32'h0000_1234, 1'b0, "R11");

        // R3 directed device selection
        write_map(32'h0000_0100);
        do_cfg(1'b0, 20'h00000, 32'h1122_3344, 0, 32'hA1B2_C3D4);
        write_map(32'h0000_8000);
        do_cfg(1'b1, 20'h7FFFF, 32'h0102_0304, 2, 32'h0);
        write_map(32'h0000_FF00);
        do_cfg(1'b0, 20'h00304, 32'hCAFE_F00D, 1, 32'h8765_4321);
        write_map(32'h0000_0C0F);
        do_cfg(1'b0, 20'h007FF, 32'h0, 0, 32'h0F0E_0D0C);
        // R4 no select bit
        write_map(32'h0000_00FF);
        do_cfg(1'b0, 20'hFFFFF, 32'h0, 3, 32'h5A5A_A5A5);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            logic [15:0] m;
            m = 16'($urandom);
            if ($urandom_range(0, 4) == 0) m[15:8] = 8'h00;
            write_map(32'(m));
            do_cfg(1'($urandom), 20'($urandom), $urandom, int'($urandom_range(0, 3)), $urandom);
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule